// File: doc/BRIEF.md
# Interpolating Gamma Table Writer

This block turns a brightness request into a complete gamma update for a display panel. The request is first limited to a legal range and rounded down to an even number. It is then split into a calibration level index and a fractional weight. Each of the 21 gamma entries is blended from two neighbouring calibration levels of a stored 9 × 21 table of 8-bit values. The table is filled through a simple write port before use.

The block sends every register write downstream as an address/value pair on a valid/ready port, for a serializer to frame. The 21 gamma writes go out first. A bank-select write follows them, and its value alternates from one update to the next. A request that arrives while an update is running is held. If several arrive, only the most recent is applied once the running update finishes. The last applied value is shown on an output.

Top module: `gamma_blend_writer`

## Requirements
- R1: A request value is limited to 10..250 and then rounded down to an even number. After reset `applied_value` reads 130. It takes the limited, rounded value in the cycle after that update's bank-select write is accepted.
- R2: With offset = value − 10, the level index is offset / 30 and the weight is offset mod 30. Nine levels, 0..8, sit 30 apart.
- R3: The table is written through `tbl_we` at (`tbl_level`, `tbl_entry`). When the weight is zero, entry e of the update is the stored byte at (level, e), unchanged.
- R4: When the weight w is non-zero, entry e is floor((lo × (30 − w) + hi × w) / 30). Here lo is the byte at (level, e) and hi is the byte at (level + 1, e). The division is exact integer division.
- R5: Entries 0..20 go out in ascending order. Entry e uses register 0x40 + 0x10 × (e / 7) + (e mod 7), so 0x40–0x46, then 0x50–0x56, then 0x60–0x66.
- R6: Register 0x39 is written after every 21st gamma write. Its value is 0x43 for the first update after reset, and then alternates between 0x34 and 0x43 on each following update.
- R7: A pulse on `bank_clr` makes the next bank-select write use 0x43. `bank_clr` takes priority over a bank-select write accepted in the same cycle.
- R8: Requests that arrive during an update are latched. When the update finishes, only the latest pending request is applied, and the ones before it produce no writes.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_reg` and `out_val` hold steady on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle brightness request strobe |
| req_value | input | 8 | Requested brightness |
| bank_clr | input | 1 | Returns the bank toggle to 0x43 |
| tbl_we | input | 1 | Table write enable |
| tbl_level | input | 4 | Table write level, 0..8 |
| tbl_entry | input | 5 | Table write entry, 0..20 |
| tbl_data | input | 8 | Table write byte |
| out_valid | output | 1 | Register write pending |
| out_ready | input | 1 | Downstream accepts the pair |
| out_reg | output | 8 | Target register address |
| out_val | output | 8 | Value to write |
| applied_value | output | 8 | Last applied limited, rounded value |

## Verification
A request is registered at the first edge and starts the update one cycle later. The level split then takes one 13-cycle divide, and each non-zero-weight entry takes another. The gamma writes therefore arrive at data-dependent times, so the bench checks them in order whenever a handshake is seen, not at fixed cycles. `applied_value` is due one edge after the bank-select handshake, and the behavioural model steps its own copy at exactly that edge and compares it on every falling edge. A stalled pair is compared again on the following falling edge to confirm it holds.

// File: rtl/gbw_pkg.sv
package gbw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEVEL,
    ST_ENTRY,
    ST_BLEND,
    ST_EMIT,
    ST_BANK
  } seq_state_t;
endpackage

// File: rtl/gbw_table.sv
module gbw_table #(
  parameter int LEVELS  = 9,
  parameter int ENTRIES = 21,
  parameter int DW      = 8,
  parameter int LW      = 4,
  parameter int EW      = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [LW-1:0] wr_lvl,
  input  logic [EW-1:0] wr_ent,
  input  logic [DW-1:0] wr_data,
  input  logic [LW-1:0] rd_lvl,
  input  logic [EW-1:0] rd_ent,
  output logic [DW-1:0] lo_data,
  output logic [DW-1:0] hi_data
);
  logic [DW-1:0] mem [LEVELS][ENTRIES];
  logic          wr_en;
  logic [LW-1:0] hi_lvl;

  // write enable qualified by address range
  assign wr_en = we && (32'(wr_lvl) < LEVELS) && (32'(wr_ent) < ENTRIES);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_lvl][wr_ent] <= wr_data;
  end

  // upper neighbour saturates at the top level
  assign hi_lvl  = (32'(rd_lvl) >= LEVELS - 1) ? LW'(LEVELS - 1) : rd_lvl + LW'(1);
  assign lo_data = mem[rd_lvl][rd_ent];
  assign hi_data = mem[hi_lvl][rd_ent];
endmodule

// File: rtl/gbw_div.sv
module gbw_div #(
  parameter int W   = 13,
  parameter int DIV = 30,
  parameter int RW  = $clog2(DIV)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  dividend,
  output logic          done,
  output logic [W-1:0]  quot,
  output logic [RW-1:0] rem
);
  localparam int CW = $clog2(W + 1);

  logic [RW:0]   part_q, part_d, trial;
  logic [W-1:0]  q_q, q_d, dvd_q, dvd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d, take;

  always_comb begin
    trial  = {part_q[RW-1:0], q_q[W-1]};
    take   = (trial >= (RW+1)'(DIV));
    part_d = part_q;
    q_d    = q_q;
    dvd_d  = dvd_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (start) begin
      part_d = '0;
      q_d    = dividend;
      dvd_d  = dividend;
      cnt_d  = CW'(W);
    end else if (cnt_q != '0) begin
      part_d = take ? (trial - (RW+1)'(DIV)) : trial;
      q_d    = {q_q[W-2:0], take};
      cnt_d  = cnt_q - CW'(1);
      done_d = (cnt_q == CW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_q <= '0;
      q_q    <= '0;
      dvd_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      part_q <= part_d;
      q_q    <= q_d;
      dvd_q  <= dvd_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;
  assign quot = q_q;
  assign rem  = part_q[RW-1:0];

  // R4: the quotient and remainder reconstruct the dividend exactly
  p_div_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((32'(quot) * DIV + 32'(rem)) == 32'(dvd_q)) && (32'(rem) < DIV));
endmodule

// File: rtl/gbw_seq.sv
module gbw_seq
  import gbw_pkg::*;
#(
  parameter int LEVELS     = 9,
  parameter int ENTRIES    = 21,
  parameter int GROUP      = 7,
  parameter int DW         = 8,
  parameter int LW         = 4,
  parameter int EW         = 5,
  parameter int NW         = 13,
  parameter int FW         = 5,
  parameter int STEP       = 30,
  parameter int VMIN       = 10,
  parameter int VMAX       = 250,
  parameter int BASE_REG   = 'h40,
  parameter int REG_STRIDE = 'h10,
  parameter int BANK_REG   = 'h39,
  parameter int BANK_A     = 'h43,
  parameter int BANK_B     = 'h34,
  parameter int RESET_VAL  = 130
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [DW-1:0] req_value,
  input  logic          bank_clr,
  output logic          div_start,
  output logic [NW-1:0] div_dividend,
  input  logic          div_done,
  input  logic [NW-1:0] div_quot,
  input  logic [FW-1:0] div_rem,
  output logic [LW-1:0] rd_lvl,
  output logic [EW-1:0] rd_ent,
  input  logic [DW-1:0] lo_data,
  input  logic [DW-1:0] hi_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_reg,
  output logic [DW-1:0] out_val,
  output logic [DW-1:0] applied_value
);
  localparam int NGRP = ENTRIES / GROUP;
  localparam int GW   = (NGRP > 1) ? $clog2(NGRP) : 1;
  localparam int PW   = (GROUP > 1) ? $clog2(GROUP) : 1;

  seq_state_t    state_q, state_d;
  logic          pend_vld_q, pend_vld_d;
  logic [DW-1:0] pend_val_q, pend_val_d;
  logic [DW-1:0] cur_q, cur_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic [FW-1:0] frac_q, frac_d;
  logic [EW-1:0] ent_q, ent_d;
  logic [GW-1:0] grp_q, grp_d;
  logic [PW-1:0] pos_q, pos_d;
  logic [DW-1:0] oval_q, oval_d;
  logic          bank_q, bank_d;
  logic [DW-1:0] applied_q, applied_d;
  logic [DW-1:0] limited, evened;
  logic [NW-1:0] blend_num;
  logic          take_pend;

  always_comb begin
    // limiting and even rounding of the pending request
    if (32'(pend_val_q) < VMIN)      limited = DW'(VMIN);
    else if (32'(pend_val_q) > VMAX) limited = DW'(VMAX);
    else                             limited = pend_val_q;
    evened    = {limited[DW-1:1], 1'b0};
    blend_num = NW'(lo_data) * (NW'(STEP) - NW'(frac_q)) + NW'(hi_data) * NW'(frac_q);

    state_d      = state_q;
    pend_vld_d   = pend_vld_q;
    pend_val_d   = pend_val_q;
    cur_d        = cur_q;
    lvl_d        = lvl_q;
    frac_d       = frac_q;
    ent_d        = ent_q;
    grp_d        = grp_q;
    pos_d        = pos_q;
    oval_d       = oval_q;
    bank_d       = bank_q;
    applied_d    = applied_q;
    div_start    = 1'b0;
    div_dividend = '0;
    take_pend    = 1'b0;

    case (state_q)
      ST_IDLE: begin
        if (pend_vld_q) begin
          take_pend    = 1'b1;
          cur_d        = evened;
          div_start    = 1'b1;
          div_dividend = NW'(evened) - NW'(VMIN);
          ent_d        = '0;
          grp_d        = '0;
          pos_d        = '0;
          state_d      = ST_LEVEL;
        end
      end
      ST_LEVEL: begin
        if (div_done) begin
          lvl_d   = LW'(div_quot);
          frac_d  = div_rem;
          state_d = ST_ENTRY;
        end
      end
      ST_ENTRY: begin
        if (frac_q == '0) begin
          oval_d  = lo_data;
          state_d = ST_EMIT;
        end else begin
          div_start    = 1'b1;
          div_dividend = blend_num;
          state_d      = ST_BLEND;
        end
      end
      ST_BLEND: begin
        if (div_done) begin
          oval_d  = DW'(div_quot);
          state_d = ST_EMIT;
        end
      end
      ST_EMIT: begin
        if (out_ready) begin
          if (32'(ent_q) == ENTRIES - 1) begin
            state_d = ST_BANK;
          end else begin
            ent_d   = ent_q + EW'(1);
            state_d = ST_ENTRY;
            if (32'(pos_q) == GROUP - 1) begin
              pos_d = '0;
              grp_d = grp_q + GW'(1);
            end else begin
              pos_d = pos_q + PW'(1);
            end
          end
        end
      end
      ST_BANK: begin
        if (out_ready) begin
          bank_d    = ~bank_q;
          applied_d = cur_q;
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (take_pend) pend_vld_d = 1'b0;
    if (req_valid) begin
      pend_vld_d = 1'b1;
      pend_val_d = req_value;
    end
    if (bank_clr) bank_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      pend_vld_q <= 1'b0;
      pend_val_q <= '0;
      cur_q      <= '0;
      lvl_q      <= '0;
      frac_q     <= '0;
      ent_q      <= '0;
      grp_q      <= '0;
      pos_q      <= '0;
      oval_q     <= '0;
      bank_q     <= 1'b0;
      applied_q  <= DW'(RESET_VAL);
    end else begin
      state_q    <= state_d;
      pend_vld_q <= pend_vld_d;
      pend_val_q <= pend_val_d;
      cur_q      <= cur_d;
      lvl_q      <= lvl_d;
      frac_q     <= frac_d;
      ent_q      <= ent_d;
      grp_q      <= grp_d;
      pos_q      <= pos_d;
      oval_q     <= oval_d;
      bank_q     <= bank_d;
      applied_q  <= applied_d;
    end
  end

  assign rd_lvl        = lvl_q;
  assign rd_ent        = ent_q;
  assign out_valid     = (state_q == ST_EMIT) || (state_q == ST_BANK);
  assign out_reg       = (state_q == ST_BANK) ? DW'(BANK_REG)
                       : DW'(BASE_REG) + DW'(grp_q) * DW'(REG_STRIDE) + DW'(pos_q);
  assign out_val       = (state_q == ST_BANK) ? (bank_q ? DW'(BANK_B) : DW'(BANK_A)) : oval_q;
  assign applied_value = applied_q;

  // R9: a stalled pair stays put
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_reg) && $stable(out_val));

  // R6: bank-select value is one of the two codes
  p_bank_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_reg == DW'(BANK_REG) |-> out_val == DW'(BANK_A) || out_val == DW'(BANK_B));

  // R1: the reported value is always legal and even
  p_applied_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    32'(applied_value) >= VMIN && 32'(applied_value) <= VMAX && !applied_value[0]);

  // R2: the level split stays inside the table
  p_split_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_ENTRY |-> 32'(frac_q) < STEP && 32'(lvl_q) < LEVELS);

  // R3: with zero weight the emitted byte equals the stored lower byte
  p_passthru_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_EMIT && frac_q == '0 |-> out_val == lo_data);

  // R5: gamma addresses stay in the colour window
  p_reg_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_reg != DW'(BANK_REG) |->
      32'(out_reg) >= BASE_REG && 32'(out_reg) < BASE_REG + NGRP * REG_STRIDE);
endmodule

// File: rtl/gamma_blend_writer.sv
module gamma_blend_writer #(
  parameter int LEVELS  = 9,
  parameter int ENTRIES = 21,
  parameter int GROUP   = 7,
  parameter int DW      = 8,
  parameter int STEP    = 30,
  parameter int VMIN    = 10,
  parameter int VMAX    = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [7:0] req_value,
  input  logic       bank_clr,
  input  logic       tbl_we,
  input  logic [3:0] tbl_level,
  input  logic [4:0] tbl_entry,
  input  logic [7:0] tbl_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_reg,
  output logic [7:0] out_val,
  output logic [7:0] applied_value
);
  localparam int LW = 4;
  localparam int EW = 5;
  localparam int FW = $clog2(STEP);
  localparam int NW = $clog2((2**DW - 1) * STEP + 1);

  logic          div_start, div_done;
  logic [NW-1:0] div_dividend, div_quot;
  logic [FW-1:0] div_rem;
  logic [LW-1:0] rd_lvl;
  logic [EW-1:0] rd_ent;
  logic [DW-1:0] lo_data, hi_data;

  gbw_table #(.LEVELS(LEVELS), .ENTRIES(ENTRIES), .DW(DW), .LW(LW), .EW(EW)) u_table (
    .clk(clk), .we(tbl_we), .wr_lvl(tbl_level), .wr_ent(tbl_entry), .wr_data(tbl_data),
    .rd_lvl(rd_lvl), .rd_ent(rd_ent), .lo_data(lo_data), .hi_data(hi_data)
  );

  gbw_div #(.W(NW), .DIV(STEP), .RW(FW)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .dividend(div_dividend),
    .done(div_done), .quot(div_quot), .rem(div_rem)
  );

  gbw_seq #(
    .LEVELS(LEVELS), .ENTRIES(ENTRIES), .GROUP(GROUP), .DW(DW), .LW(LW), .EW(EW),
    .NW(NW), .FW(FW), .STEP(STEP), .VMIN(VMIN), .VMAX(VMAX)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_value(req_value),
    .bank_clr(bank_clr), .div_start(div_start), .div_dividend(div_dividend),
    .div_done(div_done), .div_quot(div_quot), .div_rem(div_rem),
    .rd_lvl(rd_lvl), .rd_ent(rd_ent), .lo_data(lo_data), .hi_data(hi_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_reg(out_reg),
    .out_val(out_val), .applied_value(applied_value)
  );
endmodule

// File: tb/sim_gamma_blend_writer.sv
module sim_gamma_blend_writer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, bank_clr, tbl_we, out_ready, out_valid;
  logic [7:0] req_value, tbl_data, out_reg, out_val, applied_value;
  logic [3:0] tbl_level;
  logic [4:0] tbl_entry;

  typedef struct {int rg; int vl; int ap; string tg;} exp_t;
  exp_t exp_q[$];

  int   checks = 0;
  int   errors = 0;
  int   model_applied = 130;
  int   model_bank = 0;
  bit   run_mon = 0;
  bit   finished = 0;
  bit   bp_mode = 0;
  bit   hold_low = 0;
  logic [7:0] lfsr = 8'hA5;
  bit   prev_stall = 0;
  int   prev_reg, prev_val;

  always #(CLK_PERIOD/2) clk = ~clk;

  gamma_blend_writer u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_value(req_value),
    .bank_clr(bank_clr), .tbl_we(tbl_we), .tbl_level(tbl_level), .tbl_entry(tbl_entry),
    .tbl_data(tbl_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_reg(out_reg), .out_val(out_val), .applied_value(applied_value)
  );

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h) at %0t", req, act, act, expv, expv, $time);
    end
  endtask

  function automatic int tv(int l, int e);
    if (e == 20) return (l % 2 == 1) ? 255 : 0;
    return (l * 29 + e * 13 + 7) % 256;
  endfunction

  function automatic int limit_even(int v);
    int c;
    c = (v < 10) ? 10 : ((v > 250) ? 250 : v);
    return c - (c % 2);
  endfunction

  // behavioural reference: queue every pair one update must produce
  task automatic expect_update(int v, string tag);
    int c, off, lv, fr, lo, hi, val;
    exp_t x;
    c = limit_even(v);
    off = c - 10; lv = off / 30; fr = off % 30;
    for (int e = 0; e < 21; e++) begin
      lo = tv(lv, e);
      hi = (lv < 8) ? tv(lv + 1, e) : lo;
      val = (fr == 0) ? lo : (lo * (30 - fr) + hi * fr) / 30;
      x.rg = 'h40 + (e / 7) * 'h10 + (e % 7);
      x.vl = val; x.ap = -1;
      x.tg = (tag != "") ? tag : ((fr == 0) ? "R3" : "R4");
      exp_q.push_back(x);
    end
    x.rg = 'h39; x.vl = (model_bank != 0) ? 'h34 : 'h43; x.ap = c;
    x.tg = (tag == "R7") ? "R7" : "R6";
    exp_q.push_back(x);
    model_bank ^= 1;
  endtask

  task automatic send(int v);
    @(posedge clk); #1; req_valid = 1'b1; req_value = 8'(v);
    @(posedge clk); #1; req_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    #1;
  endtask

  // ready driver
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready <= hold_low ? 1'b0 : (bp_mode ? (lfsr[0] | lfsr[2]) : 1'b1);
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && run_mon && !finished) begin
      chk(int'(applied_value) == model_applied, "R1", applied_value, model_applied);
      if (prev_stall) begin
        chk(out_valid && int'(out_reg) == prev_reg && int'(out_val) == prev_val, "R9",
            {out_valid, out_reg, out_val}, {1'b1, 8'(prev_reg), 8'(prev_val)});
      end
      prev_stall = out_valid && !out_ready;
      prev_reg = out_reg; prev_val = out_val;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8", out_reg, -1);
        end else begin
          exp_t x;
          x = exp_q.pop_front();
          chk(int'(out_reg) == x.rg, (x.tg == "R8") ? "R8" : "R5", out_reg, x.rg);
          chk(int'(out_val) == x.vl, x.tg, out_val, x.vl);
          if (x.ap >= 0) model_applied = x.ap;
        end
      end
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_value = '0; bank_clr = 1'b0;
    tbl_we = 1'b0; tbl_level = '0; tbl_entry = '0; tbl_data = '0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    chk(applied_value == 8'd130, "R1", applied_value, 130);

    // R3: table load through the write port
    for (int l = 0; l < 9; l++) begin
      for (int e = 0; e < 21; e++) begin
        @(posedge clk); #1;
        tbl_we = 1'b1; tbl_level = 4'(l); tbl_entry = 5'(e); tbl_data = 8'(tv(l, e));
      end
    end
    @(posedge clk); #1 tbl_we = 1'b0;
    run_mon = 1;

    expect_update(130, "R3"); send(130); drain();   // level 4, weight 0
    expect_update(5, "R1");   send(5);   drain();   // limited to 10
    expect_update(255, "R1"); send(255); drain();   // limited to 250, level 8
    expect_update(47, "R2");  send(47);  drain();   // 46: level 1, weight 6
    expect_update(139, "");   send(139); drain();   // 138: level 4, weight 8
    expect_update(249, "");   send(249); drain();   // 248: level 7, weight 28

    // R9: random backpressure
    bp_mode = 1;
    expect_update(77, "R4");  send(77);  drain();
    expect_update(201, "R4"); send(201); drain();
    bp_mode = 0;

    // R8: only the newest of several pending requests is applied
    hold_low = 1;
    expect_update(100, "");
    send(100);
    repeat (5) @(posedge clk);
    send(60);
    send(180);
    expect_update(180, "R8");
    repeat (3) @(posedge clk);
    #1 hold_low = 0;
    drain();

    // R7: clear the toggle while it points to 0x34
    if (model_bank == 0) begin expect_update(40, ""); send(40); drain(); end
    @(posedge clk); #1 bank_clr = 1'b1;
    @(posedge clk); #1 bank_clr = 1'b0;
    model_bank = 0;
    expect_update(164, "R7"); send(164); drain();
    expect_update(22, "R6");  send(22);  drain();

    chk(exp_q.size() == 0, "R8", exp_q.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d pending pairs", exp_q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule